// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block is a register-mapped station-management master. It assembles a Clause-22 management frame and shifts it onto a management clock (MDC) and a bidirectional data line (MDIO). Software sets a clock divisor and, for writes, a 16-bit data word. It then writes a frame-control word that carries a start flag, and the block sends the whole frame on its own. The data line is split into a driven value, an output enable and a sampled input, so the pad logic outside the block forms the tristate.

Each frame has 64 bit times:
- a 32-bit preamble of ones;
- the two start-of-frame bits and the two opcode bits, taken exactly as software wrote them;
- the five PHY address bits and the five register address bits;
- two turnaround bits;
- sixteen data bits.

During a read the master releases the line from the first turnaround bit onward. It samples the second turnaround bit, which lets the PHY report failure. It then shifts in the sixteen data bits. The start flag reads back as a busy indication, so software can poll for completion.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at byte addresses 0x0 (divisor in bits 7:0), 0x4 (write data in bits 15:0), 0x8 (frame control) and 0xC (status). The divisor and write-data registers read back what was written, with zeros in the unused bits.
- R2: In the frame-control word, bit 31 is the start flag, bits 20:16 the register address, bits 8:4 the PHY address, bits 3:2 the opcode and bits 1:0 the start-of-frame code. A write with bit 31 set while idle starts a frame.
- R3: Each MDC half period lasts divisor+1 system clocks. A divisor of 0 acts as 1. The divisor is taken at frame start, and a whole frame lasts 128 half periods.
- R4: On the wire, MSB first, the frame is 32 ones, then start code, opcode, PHY address and register address. MDIO changes only when MDC falls.
- R5: For any opcode other than 10, the master sends turnaround 1 then 0, followed by the 16 bits of the write-data register.
- R6: For opcode 10 (read), the output enable is low for the last 18 bit times, from the first turnaround bit to the end. MDIO is sampled on each rising MDC edge. The 16 data bits appear MSB first in status bits 15:0.
- R7: Status bit 24 is the inverse of the MDIO level sampled in the second turnaround bit of a read.
- R8: Frame-control bit 31 reads 1 from the clock after the start until the frame ends, and 0 afterwards. The other fields keep their written values.
- R9: Any write to the frame-control register while a frame is in progress is ignored. The fields do not change, no second frame starts, and the frame in flight is unaltered.
- R10: After reset and between frames, MDC is high and the output enable is low. After reset all registers read 0.
- R11: A frame-control write with bit 31 clear while idle updates the fields but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Sampled MDIO level |

## Verification
The hardest case to reach from the ports is a frame-control write that arrives in the middle of a frame. It must leave the frame in flight and the readback fields unchanged. The bench reaches it by starting a slow read and issuing a conflicting start write partway through. It then checks the readback fields, the captured bit stream and the total frame length. A bench model of a PHY follows MDC and drives the turnaround and data bits back. This covers both read-OK outcomes and the all-ones and mixed data patterns, and the smallest divisor is included.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W      = 8;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Bit positions inside the frame (0 = first bit on the wire)
    localparam int TA1_POS  = 46;
    localparam int TA2_POS  = 47;
    localparam int DATA_POS = 48;

    // Frame-control word layout
    localparam int TRIG_BIT = 31;
    localparam int RG_LSB   = 16;
    localparam int PHY_LSB  = 4;
    localparam int OP_LSB   = 2;
    localparam int SOF_LSB  = 0;
    localparam int OK_BIT   = 24;

    localparam logic [1:0] OP_RD = 2'b10;

    typedef struct packed {
        logic [4:0] rg;
        logic [4:0] phy;
        logic [1:0] op;
        logic [1:0] sof;
    } frame_hdr_t;

    typedef struct packed {
        frame_hdr_t        hdr;
        logic [DATA_W-1:0] wdata;
        logic [DIV_W-1:0]  div;
    } frame_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input frame_req_t r);
        return {{PRE_BITS{1'b1}}, r.hdr.sof, r.hdr.op, r.hdr.phy, r.hdr.rg,
                2'b10, r.wdata};
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic frame_hdr_t hdr_from_word(input logic [31:0] w);
        frame_hdr_t h;
        h.rg  = w[RG_LSB +: 5];
        h.phy = w[PHY_LSB +: 5];
        h.op  = w[OP_LSB +: 2];
        h.sof = w[SOF_LSB +: 2];
        return h;
    endfunction

    function automatic logic [31:0] hdr_to_word(input frame_hdr_t h, input logic busy);
        logic [31:0] w;
        w = '0;
        w[TRIG_BIT]       = busy;
        w[RG_LSB +: 5]    = h.rg;
        w[PHY_LSB +: 5]   = h.phy;
        w[OP_LSB +: 2]    = h.op;
        w[SOF_LSB +: 2]   = h.sof;
        return w;
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  busy,
    input  logic [DATA_W-1:0]     rd_data,
    input  logic                  rd_ok,
    output logic                  start,
    output frame_req_t            req
);

    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] A_WD   = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4'hC);

    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] wd_q;
    frame_hdr_t        hdr_q;
    frame_hdr_t        hdr_in;
    logic              cfg_wr;
    logic              unused_wbits;

    assign hdr_in = hdr_from_word(reg_wdata);
    assign cfg_wr = reg_we && (reg_addr == A_CFG) && !busy;
    assign start  = cfg_wr && reg_wdata[TRIG_BIT];

    assign req.hdr   = hdr_in;
    assign req.wdata = wd_q;
    assign req.div   = div_q;

    assign unused_wbits = ^{reg_wdata[30:21], reg_wdata[15:9]};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            wd_q  <= '0;
            hdr_q <= '0;
        end else begin
            if (reg_we && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
            if (reg_we && reg_addr == A_WD)  wd_q  <= reg_wdata[DATA_W-1:0];
            if (cfg_wr)                      hdr_q <= hdr_in;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DIV:  reg_rdata[DIV_W-1:0]  = div_q;
            A_WD:   reg_rdata[DATA_W-1:0] = wd_q;
            A_CFG:  reg_rdata = hdr_to_word(hdr_q, busy);
            A_STAT: begin
                reg_rdata[DATA_W-1:0] = rd_data;
                reg_rdata[OK_BIT]     = rd_ok;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_halfcnt.sv
module mdio_halfcnt
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt_q <= '0;
        else if (cnt_q == lim)      cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_req_t        req,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DIV_W-1:0]  lim,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    logic                  busy_q;
    logic                  mdc_q;
    logic                  is_rd_q;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic [DIV_W-1:0]      div_q;
    logic [DATA_W-1:0]     rd_q;
    logic                  ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            mdc_q   <= 1'b1;
            is_rd_q <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
            div_q   <= '0;
            rd_q    <= '0;
            ok_q    <= 1'b0;
        end else if (start) begin
            busy_q  <= 1'b1;
            mdc_q   <= 1'b0;
            idx_q   <= '0;
            frame_q <= build_frame(req);
            is_rd_q <= (req.hdr.op == OP_RD);
            div_q   <= eff_div(req.div);
        end else if (busy_q && tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (is_rd_q) begin
                    if (idx_q == IDX_W'(TA2_POS)) ok_q <= ~mdio_i;
                    if (idx_q >= IDX_W'(DATA_POS)) rd_q <= {rd_q[DATA_W-2:0], mdio_i};
                end
            end else if (idx_q == LAST) begin
                busy_q <= 1'b0;
            end else begin
                mdc_q <= 1'b0;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign mdc     = mdc_q;
    assign lim     = div_q;
    assign rd_data = rd_q;
    assign rd_ok   = ok_q;
    assign mdio_o  = busy_q ? frame_q[LAST - idx_q] : 1'b1;
    assign mdio_oe = busy_q && !(is_rd_q && idx_q >= IDX_W'(TA1_POS));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic              busy;
    logic              start;
    logic              tick;
    frame_req_t        req;
    logic [DIV_W-1:0]  lim;
    logic [DATA_W-1:0] rd_data;
    logic              rd_ok;

    mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .rd_data   (rd_data),
        .rd_ok     (rd_ok),
        .start     (start),
        .req       (req)
    );

    mdio_halfcnt u_half (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (start),
        .lim     (lim),
        .tick    (tick)
    );

    mdio_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req     (req),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .lim     (lim),
        .rd_data (rd_data),
        .rd_ok   (rd_ok)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(4'h8);

    // R10: idle bus state
    p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && !mdio_oe));

    // R4: data changes only together with a falling MDC
    p_change_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

    // R3: a half period is never shorter than two system clocks
    p_min_half_r3: assert property (@(posedge clk) disable iff (rst)
        (mdc != $past(mdc)) |=> (mdc == $past(mdc)));

    // R6: output enable only rises at the start of a frame, with MDC falling
    p_oe_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> $fell(mdc));

    // R9: frame-control fields are frozen while a frame is in flight
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && reg_addr == A_CFG && $past(reg_addr) == A_CFG)
            |-> $stable(reg_rdata[30:0]));

endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

    localparam int ADDR_W = 4;
    localparam logic [3:0] A_DIV = 4'h0, A_WD = 4'h4, A_CFG = 4'h8, A_STAT = 4'hC;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [7:0]  div;
        logic [15:0] resp;
        logic        ta2;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [0:NV-1] = '{
        '{2'b01, 5'h01, 5'h00, 16'hA5C3, 8'd2, 16'h0000, 1'b0},
        '{2'b10, 5'h1F, 5'h02, 16'h0000, 8'd1, 16'h1234, 1'b0},
        '{2'b10, 5'h0A, 5'h1F, 16'h0000, 8'd3, 16'hFFFF, 1'b1},
        '{2'b01, 5'h10, 5'h15, 16'h8001, 8'd0, 16'h0000, 1'b0},
        '{2'b10, 5'h00, 5'h01, 16'h0000, 8'd0, 16'h8001, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY model state
    int          rcnt = 0;
    int          lowcnt = 0;
    int          firstlow = -1;
    logic [63:0] cap = '0;
    logic [15:0] phy_resp = '0;
    logic        phy_ta2 = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_master #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        if (!rst) begin
            cap = {cap[62:0], mdio_o};
            if (!mdio_oe) begin
                if (firstlow < 0) firstlow = rcnt;
                lowcnt = lowcnt + 1;
            end
            rcnt = rcnt + 1;
        end
    end

    always @(negedge mdc) begin
        if (rcnt == 47)      mdio_i = phy_ta2;
        else if (rcnt >= 48) mdio_i = phy_resp[63-rcnt];
        else                 mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfg_word(input logic trig, input logic [1:0] op,
                                              input logic [4:0] phy, input logic [4:0] rg);
        return {trig, 10'b0, rg, 7'b0, phy, op, 2'b01};
    endfunction

    task automatic arm(input logic [15:0] resp, input logic ta2);
        rcnt = 0; lowcnt = 0; firstlow = -1; cap = '0;
        phy_resp = resp; phy_ta2 = ta2;
    endtask

    // Returns cycles from the start edge until busy clears
    task automatic wait_done(input int c0, output int dur);
        reg_addr = A_CFG;
        #1;
        while (reg_rdata[31]) begin
            @(negedge clk);
            #1;
        end
        dur = cyc - c0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] exp;
        int dur, c0, dd;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        #1;
        chk(mdc === 1'b1 && mdio_oe === 1'b0, "R10 idle after reset", {mdc, mdio_oe}, 2'b10);
        rd(A_CFG, d);  chk(d == 0, "R10 cfg reset", d, 0);
        rd(A_STAT, d); chk(d == 0, "R10 status reset", d, 0);
        rd(A_DIV, d);  chk(d == 0, "R10 divisor reset", d, 0);

        // R1: readback of divisor and write data
        wr(A_DIV, 32'hFFFF_FF5A); rd(A_DIV, d); chk(d == 32'h5A, "R1 divisor readback", d, 32'h5A);
        wr(A_WD, 32'h1234_BEEF);  rd(A_WD, d);  chk(d == 32'hBEEF, "R1 wdata readback", d, 32'hBEEF);

        // R11: field write without start flag
        wr(A_CFG, cfg_word(1'b0, 2'b10, 5'h07, 5'h09));
        repeat (20) @(negedge clk);
        #1 chk(mdc === 1'b1 && mdio_oe === 1'b0, "R11 no frame started", {mdc, mdio_oe}, 2'b10);
        rd(A_CFG, d);
        chk(d == cfg_word(1'b0, 2'b10, 5'h07, 5'h09), "R11 fields updated", d, cfg_word(1'b0, 2'b10, 5'h07, 5'h09));

        // Table-driven frames: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            wr(A_DIV, {24'h0, v.div});
            wr(A_WD, {16'h0, v.wd});
            arm(v.resp, v.ta2);
            wr(A_CFG, cfg_word(1'b1, v.op, v.phy, v.rg));
            c0 = cyc;
            #1 chk(reg_rdata[31] === 1'b1, "R8 busy after start", reg_rdata[31], 1);
            wait_done(c0, dur);
            dd = (v.div == 0) ? 1 : int'(v.div);
            chk(dur == 128 * (dd + 1), "R3 frame length", dur, 128 * (dd + 1));
            chk(rcnt == 64, "R2 bit count", rcnt, 64);
            exp = {32'hFFFF_FFFF, 2'b01, v.op, v.phy, v.rg, 2'b10, v.wd};
            if (v.op == 2'b10) begin
                chk(cap[63:18] == exp[63:18], "R4 read header bits", cap[63:18], exp[63:18]);
                chk(lowcnt == 18 && firstlow == 46, "R6 release window", {lowcnt[15:0], firstlow[15:0]}, {16'd18, 16'd46});
                rd(A_STAT, d);
                chk(d[15:0] == v.resp, "R6 read data", d[15:0], v.resp);
                chk(d[24] == ~v.ta2, "R7 read ok flag", d[24], ~v.ta2);
            end else begin
                chk(cap == exp, "R5 write frame bits", cap, exp);
                chk(lowcnt == 0, "R5 driven whole frame", lowcnt, 0);
            end
            rd(A_CFG, d);
            chk(d == cfg_word(1'b0, v.op, v.phy, v.rg), "R8 busy clear fields kept", d, cfg_word(1'b0, v.op, v.phy, v.rg));
            #1 chk(mdc === 1'b1 && mdio_oe === 1'b0, "R10 idle after frame", {mdc, mdio_oe}, 2'b10);
        end

        // R9: start write during a frame is ignored
        wr(A_DIV, 32'h0);
        arm(16'h5AA5, 1'b0);
        wr(A_CFG, cfg_word(1'b1, 2'b10, 5'h03, 5'h04));
        c0 = cyc;
        repeat (40) @(negedge clk);
        wr(A_CFG, cfg_word(1'b1, 2'b01, 5'h1C, 5'h0E));
        rd(A_CFG, d);
        chk(d == cfg_word(1'b1, 2'b10, 5'h03, 5'h04), "R9 fields unchanged", d, cfg_word(1'b1, 2'b10, 5'h03, 5'h04));
        wait_done(c0, dur);
        chk(dur == 256, "R9 single frame length", dur, 256);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h04, 2'b10, 16'h0};
        chk(cap[63:18] == exp[63:18], "R9 frame unaltered", cap[63:18], exp[63:18]);
        rd(A_STAT, d);
        chk(d[15:0] == 16'h5AA5 && d[24], "R9 read completes", d, 32'h0100_5AA5);
        repeat (10) @(negedge clk);
        #1 chk(mdc === 1'b1 && rcnt == 64, "R9 no second frame", rcnt, 64);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule